// File: doc/BRIEF.md
# Multi-channel timer PWM bank

The block holds a row of independent timer channels. Each channel has its own up-counter, duty compare value, period compare value and a small control word. Every channel produces one PWM pin and one running flag. A counter moves only on clock edges where the channel's tick strobe is high and the channel has been started. When the counter equals the period value, the next counted tick brings it back to zero. The pin rests at a programmable idle level while the count is below the duty value. From the duty value up to the period value it takes the other level.

Software uses a single write port and a combinational read port, both on word addresses. Counters are started and stopped through two shared write-one masks, so one channel can be handled without a read-modify-write of the others. To park a pin cleanly, software sets the duty value above the period value, or clears the output enable. Clearing the enable either cuts the pulse at once or lets the running period end first, depending on a control bit. Software may also load the counter directly before a restart.

Top module: `tmr_pwm_bank`

## Requirements
- R1: After reset every counter, duty value, period value and control word reads zero, no channel runs, and every pin is low.
- R2: A channel's counter increments by one on each clock edge where that channel is running and its tick input is high. Otherwise the counter holds its value.
- R3: A running channel whose count equals its period value goes to zero on the next ticked edge, not to period+1.
- R4: A write of mask M to the start address (4*N) sets the running flag of every channel n with bit n of M set. A write to the stop address (4*N+1) clears those flags. Zero bits change nothing. The flags appear on run_o and read back at address 4*N+2.
- R5: With output enabled, the pin is at the idle level while count < duty, and at the opposite level while duty <= count <= period. Control bit 1 gives the idle level: 1 is high, 0 is low.
- R6: When the duty value is greater than the period value, the pin stays at the idle level through any number of periods.
- R7: With control bit 0 (output enable) clear, once any pulse in progress has ended, the pin is at the idle level whatever the count.
- R8: With control bit 2 set (abrupt), a write that clears the output enable puts the pin at the idle level from the cycle after the write.
- R9: With control bit 2 clear (graceful), a write that clears the output enable leaves an active pulse running until the counter wraps to zero or the channel stops. After that the pin stays idle.
- R10: A write to a channel's count address loads the value on that edge, overriding any increment.
- R11: Channel n uses address 4n+0 for the count, 4n+1 for the duty value, 4n+2 for the period value and 4n+3 for the control word (bit 0 enable, bit 1 idle-high, bit 2 abrupt). Reads are combinational from rd_addr.
- R12: A write or a tick on one channel changes no other channel's count, flag or pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | AW | Write word address |
| wr_data | input | CW | Write data |
| rd_addr | input | AW | Read word address |
| rd_data | output | CW | Read data, combinational |
| tick | input | NCH | Per-channel count enable |
| pwm_o | output | NCH | PWM pin per channel |
| run_o | output | NCH | Running flag per channel |

## Verification
A wrong count shows at the count read port on the very next sample, and it shifts the pin edges by the same number of cycles. The bench therefore steps through full periods and compares the count sequence and the pin level on every cycle. A wrong output gate is visible only after the enable is cleared. It shows as a pin that drops one wrap too early or stays active past the wrap, so the bench clears the enable in the middle of a pulse in both shutdown modes and follows the pin across the wrap. A wrong running flag freezes or frees the counter at once, and it shows on run_o in the cycle after the start or stop write.

// File: rtl/tmr_pwm_pkg.sv
package tmr_pwm_pkg;

    // Per-channel control word, low bits of the control register
    typedef struct packed {
        logic abrupt;     // bit 2: cut pulse immediately when disabled
        logic init_high;  // bit 1: idle level is high
        logic out_en;     // bit 0: pin follows the compare phase
    } ctl_t;

    localparam int CTL_W     = 3;
    localparam int CH_STRIDE = 4;
    localparam int OFS_CNT   = 0;
    localparam int OFS_DUTY  = 1;
    localparam int OFS_PER   = 2;
    localparam int OFS_CTL   = 3;
    localparam int G_SET     = 0;
    localparam int G_CLR     = 1;
    localparam int G_STAT    = 2;

endpackage

// File: rtl/tmr_pwm_chan.sv
module tmr_pwm_chan
    import tmr_pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_cnt,
    input  logic          wr_duty,
    input  logic          wr_per,
    input  logic          wr_ctl,
    input  logic          start,
    input  logic          stop,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] duty_o,
    output logic [CW-1:0] per_o,
    output ctl_t          ctl_o,
    output logic          run_o,
    output logic          pwm_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] duty;
        logic [CW-1:0] per;
        ctl_t          ctl;
        logic          run;
        logic          gate;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     wrap;
    logic     phase;

    always_comb begin
        st_d = st_q;
        wrap = st_q.run && tick && (st_q.cnt == st_q.per);

        if (st_q.run && tick) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
        if (wr_cnt)  st_d.cnt  = wdata;
        if (wr_duty) st_d.duty = wdata;
        if (wr_per)  st_d.per  = wdata;
        if (wr_ctl)  st_d.ctl  = ctl_t'(wdata[CTL_W-1:0]);

        if (start) st_d.run = 1'b1;
        if (stop)  st_d.run = 1'b0;

        // Output gate: opens with the enable, closes at once (abrupt) or
        // at the end of the running period (graceful)
        if (st_d.ctl.out_en) begin
            st_d.gate = 1'b1;
        end else if (st_d.ctl.abrupt || wrap || !st_q.run) begin
            st_d.gate = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase  = (st_q.cnt >= st_q.duty) && (st_q.duty <= st_q.per);
    assign pwm_o  = st_q.ctl.init_high ^ (st_q.gate & phase);
    assign cnt_o  = st_q.cnt;
    assign duty_o = st_q.duty;
    assign per_o  = st_q.per;
    assign ctl_o  = st_q.ctl;
    assign run_o  = st_q.run;

endmodule

// File: rtl/tmr_pwm_regif.sv
module tmr_pwm_regif
    import tmr_pwm_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int AW  = 6
) (
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [NCH-1:0]          wmask,
    input  logic [AW-1:0]           rd_addr,
    input  logic [NCH-1:0][CW-1:0]  cnt_all,
    input  logic [NCH-1:0][CW-1:0]  duty_all,
    input  logic [NCH-1:0][CW-1:0]  per_all,
    input  ctl_t [NCH-1:0]          ctl_all,
    input  logic [NCH-1:0]          run_all,
    output logic [NCH-1:0]          wr_cnt_v,
    output logic [NCH-1:0]          wr_duty_v,
    output logic [NCH-1:0]          wr_per_v,
    output logic [NCH-1:0]          wr_ctl_v,
    output logic [NCH-1:0]          start_v,
    output logic [NCH-1:0]          stop_v,
    output logic [CW-1:0]           rd_data
);

    localparam int GBASE = CH_STRIDE * NCH;

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign wr_cnt_v[i]  = wr_en && (wr_addr == AW'(CH_STRIDE*i + OFS_CNT));
        assign wr_duty_v[i] = wr_en && (wr_addr == AW'(CH_STRIDE*i + OFS_DUTY));
        assign wr_per_v[i]  = wr_en && (wr_addr == AW'(CH_STRIDE*i + OFS_PER));
        assign wr_ctl_v[i]  = wr_en && (wr_addr == AW'(CH_STRIDE*i + OFS_CTL));
    end

    assign start_v = (wr_en && (wr_addr == AW'(GBASE + G_SET))) ? wmask : '0;
    assign stop_v  = (wr_en && (wr_addr == AW'(GBASE + G_CLR))) ? wmask : '0;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == AW'(CH_STRIDE*i + OFS_CNT))  rd_data = cnt_all[i];
            if (rd_addr == AW'(CH_STRIDE*i + OFS_DUTY)) rd_data = duty_all[i];
            if (rd_addr == AW'(CH_STRIDE*i + OFS_PER))  rd_data = per_all[i];
            if (rd_addr == AW'(CH_STRIDE*i + OFS_CTL))  rd_data = CW'(ctl_all[i]);
        end
        if (rd_addr == AW'(GBASE + G_STAT)) rd_data = CW'(run_all);
    end

endmodule

// File: rtl/tmr_pwm_bank.sv
module tmr_pwm_bank
    import tmr_pwm_pkg::*;
#(
    parameter  int NCH = 8,
    parameter  int CW  = 16,
    localparam int AW  = $clog2(CH_STRIDE*NCH + G_STAT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [CW-1:0]  rd_data,
    input  logic [NCH-1:0] tick,
    output logic [NCH-1:0] pwm_o,
    output logic [NCH-1:0] run_o
);

    logic [NCH-1:0][CW-1:0] cnt_all;
    logic [NCH-1:0][CW-1:0] duty_all;
    logic [NCH-1:0][CW-1:0] per_all;
    ctl_t [NCH-1:0]         ctl_all;
    logic [NCH-1:0]         wr_cnt_v, wr_duty_v, wr_per_v, wr_ctl_v;
    logic [NCH-1:0]         start_v, stop_v;

    tmr_pwm_regif #(.NCH(NCH), .CW(CW), .AW(AW)) u_regif (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wmask     (wr_data[NCH-1:0]),
        .rd_addr   (rd_addr),
        .cnt_all   (cnt_all),
        .duty_all  (duty_all),
        .per_all   (per_all),
        .ctl_all   (ctl_all),
        .run_all   (run_o),
        .wr_cnt_v  (wr_cnt_v),
        .wr_duty_v (wr_duty_v),
        .wr_per_v  (wr_per_v),
        .wr_ctl_v  (wr_ctl_v),
        .start_v   (start_v),
        .stop_v    (stop_v),
        .rd_data   (rd_data)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_pwm_chan #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick[i]),
            .wr_cnt  (wr_cnt_v[i]),
            .wr_duty (wr_duty_v[i]),
            .wr_per  (wr_per_v[i]),
            .wr_ctl  (wr_ctl_v[i]),
            .start   (start_v[i]),
            .stop    (stop_v[i]),
            .wdata   (wr_data),
            .cnt_o   (cnt_all[i]),
            .duty_o  (duty_all[i]),
            .per_o   (per_all[i]),
            .ctl_o   (ctl_all[i]),
            .run_o   (run_o[i]),
            .pwm_o   (pwm_o[i])
        );
    end

endmodule

// File: rtl/tmr_pwm_chk.sv
module tmr_pwm_chk
    import tmr_pwm_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int AW  = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [AW-1:0]          wr_addr,
    input logic [NCH-1:0]         wmask,
    input logic [NCH-1:0]         tick,
    input logic [NCH-1:0]         run_o,
    input logic [NCH-1:0]         pwm_o,
    input logic [NCH-1:0][CW-1:0] cnt_all,
    input logic [NCH-1:0][CW-1:0] duty_all,
    input logic [NCH-1:0][CW-1:0] per_all,
    input ctl_t [NCH-1:0]         ctl_all
);

    localparam int SET_A = CH_STRIDE*NCH + G_SET;
    localparam int CLR_A = CH_STRIDE*NCH + G_CLR;

    AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(SET_A)) |=> ((run_o & $past(wmask)) == $past(wmask))); // R4
    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(CLR_A)) |=> ((run_o & $past(wmask)) == '0)); // R4
    AST_RUN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(run_o)); // R4

    for (genvar i = 0; i < NCH; i++) begin : g_ast
        AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick[i] && !wr_en) |=> $stable(cnt_all[i])); // R2
        AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (run_o[i] && tick[i] && cnt_all[i] == per_all[i] && !wr_en) |=> (cnt_all[i] == '0)); // R3
        AST_FAR_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_all[i] > per_all[i]) |-> (pwm_o[i] == ctl_all[i].init_high)); // R6
        AST_ABRUPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl_all[i].out_en && ctl_all[i].abrupt) |-> (pwm_o[i] == ctl_all[i].init_high)); // R8
    end

endmodule

bind tmr_pwm_bank tmr_pwm_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wmask    (wr_data[NCH-1:0]),
    .tick     (tick),
    .run_o    (run_o),
    .pwm_o    (pwm_o),
    .cnt_all  (cnt_all),
    .duty_all (duty_all),
    .per_all  (per_all),
    .ctl_all  (ctl_all)
);

// File: tb/sim_tmr_pwm_bank.sv
module sim_tmr_pwm_bank;

    localparam int CLK_NS = 10;
    localparam int NCH    = 8;
    localparam int CW     = 16;
    localparam int AW     = 6;
    localparam int SET_A  = 4*NCH;
    localparam int CLR_A  = 4*NCH + 1;
    localparam int STAT_A = 4*NCH + 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [CW-1:0]  wr_data = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [CW-1:0]  rd_data;
    logic [NCH-1:0] tick = '0;
    logic [NCH-1:0] pwm_o;
    logic [NCH-1:0] run_o;

    int n_chk = 0;
    int n_bad = 0;

    tmr_pwm_bank #(.NCH(NCH), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .pwm_o(pwm_o), .run_o(run_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = CW'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = AW'(a);
        #1;
        v = int'(rd_data);
    endtask

    function automatic int adr(input int ch, input int ofs);
        return 4*ch + ofs;
    endfunction

    task automatic prog(input int ch, input int c, input int d, input int p, input int ctl);
        wr(CLR_A, 1 << ch);
        wr(adr(ch, 0), c);
        wr(adr(ch, 1), d);
        wr(adr(ch, 2), p);
        wr(adr(ch, 3), ctl);
    endtask

    task automatic wait_cnt(input int ch, input int val);
        int v;
        for (int k = 0; k < 40; k++) begin
            rd(adr(ch, 0), v);
            if (v == val) break;
            step(1);
        end
        chk("wait count reached", v, val);
    endtask

    task automatic t_reset;
        int v;
        chk("R1 status port", int'(run_o), 0);
        chk("R1 pins", int'(pwm_o), 0);
        rd(STAT_A, v);    chk("R1 status reg", v, 0);
        rd(adr(2, 0), v); chk("R1 count", v, 0);
        rd(adr(2, 2), v); chk("R1 period", v, 0);
        rd(adr(2, 3), v); chk("R1 control", v, 0);
    endtask

    task automatic t_setclr;
        int v;
        wr(SET_A, 5);
        chk("R4 run after set", int'(run_o), 5);
        rd(STAT_A, v); chk("R11 status reg", v, 5);
        wr(SET_A, 0);  chk("R4 set zero mask", int'(run_o), 5);
        wr(CLR_A, 1);  chk("R4 clear bit0", int'(run_o), 4);
        wr(CLR_A, 0);  chk("R4 clear zero mask", int'(run_o), 4);
        wr(CLR_A, 4);  chk("R4 clear bit2", int'(run_o), 0);
        rd(adr(0, 0), v); chk("R2 no tick no count", v, 0);
    endtask

    task automatic t_tick;
        int v;
        prog(3, 0, 0, 100, 0);
        wr(SET_A, 8);
        step(4);
        rd(adr(3, 0), v); chk("R2 held without tick", v, 0);
        tick[3] = 1'b1;
        step(3);
        tick[3] = 1'b0;
        rd(adr(3, 0), v); chk("R2 three ticks", v, 3);
        step(2);
        rd(adr(3, 0), v); chk("R2 holds after ticks", v, 3);
        rd(adr(4, 0), v); chk("R12 neighbour count", v, 0);
        chk("R12 neighbour run", int'(run_o[4]), 0);
        wr(CLR_A, 8);
    endtask

    task automatic t_wave;
        int v;
        prog(2, 0, 3, 7, 1);
        rd(adr(2, 1), v); chk("R11 duty read", v, 3);
        rd(adr(2, 2), v); chk("R11 period read", v, 7);
        rd(adr(2, 3), v); chk("R11 control read", v, 1);
        tick[2] = 1'b1;
        wr(SET_A, 4);
        for (int k = 0; k < 16; k++) begin
            rd(adr(2, 0), v);
            chk("R3 count sequence", v, k % 8);
            chk("R5 pin low idle", int'(pwm_o[2]), int'((k % 8) >= 3));
            step(1);
        end
        wr(CLR_A, 4);
        rd(adr(2, 0), v);
        step(3);
        begin
            int v2;
            rd(adr(2, 0), v2);
            chk("R4 stopped count holds", v2, v);
        end
        chk("R4 run cleared", int'(run_o[2]), 0);
    endtask

    task automatic t_inv;
        prog(2, 0, 3, 7, 3);
        wr(SET_A, 4);
        for (int k = 0; k < 8; k++) begin
            chk("R5 pin high idle", int'(pwm_o[2]), int'(!(k >= 3)));
            step(1);
        end
    endtask

    task automatic t_far_duty;
        prog(2, 0, 9, 7, 1);
        wr(SET_A, 4);
        for (int k = 0; k < 20; k++) begin
            chk("R6 idle low", int'(pwm_o[2]), 0);
            step(1);
        end
        wr(adr(2, 3), 3);
        for (int k = 0; k < 20; k++) begin
            chk("R6 idle high", int'(pwm_o[2]), 1);
            step(1);
        end
    endtask

    task automatic t_oe_off;
        prog(2, 0, 3, 7, 2);
        wr(SET_A, 4);
        for (int k = 0; k < 16; k++) begin
            chk("R7 disabled pin", int'(pwm_o[2]), 1);
            step(1);
        end
    endtask

    task automatic t_abrupt;
        int v;
        prog(2, 0, 3, 7, 5);
        wr(SET_A, 4);
        wait_cnt(2, 4);
        chk("R8 active before cut", int'(pwm_o[2]), 1);
        wr(adr(2, 3), 4);
        for (int j = 0; j < 11; j++) begin
            rd(adr(2, 0), v);
            chk("R8 count runs on", v, (5 + j) % 8);
            chk("R8 pin cut", int'(pwm_o[2]), 0);
            step(1);
        end
    endtask

    task automatic t_graceful;
        int v;
        prog(2, 0, 3, 7, 1);
        wr(SET_A, 4);
        wait_cnt(2, 4);
        chk("R9 active before stop", int'(pwm_o[2]), 1);
        wr(adr(2, 3), 0);
        for (int j = 0; j < 11; j++) begin
            rd(adr(2, 0), v);
            chk("R9 count runs on", v, (5 + j) % 8);
            chk("R9 pulse finishes", int'(pwm_o[2]), int'(j < 3));
            step(1);
        end
        wr(CLR_A, 4);
        tick[2] = 1'b0;
    endtask

    task automatic t_cnt_write;
        int v;
        prog(5, 0, 0, 100, 0);
        tick[5] = 1'b1;
        wr(SET_A, 32);
        step(2);
        wr(adr(5, 0), 50);
        rd(adr(5, 0), v); chk("R10 load beats increment", v, 50);
        step(1);
        rd(adr(5, 0), v); chk("R10 counts from load", v, 51);
        tick[5] = 1'b0;
        wr(adr(5, 0), 2);
        rd(adr(5, 0), v); chk("R10 load idle", v, 2);
        step(3);
        rd(adr(5, 0), v); chk("R2 load then hold", v, 2);
        rd(adr(0, 0), v); chk("R12 channel0 count", v, 0);
        chk("R12 channel0 pin", int'(pwm_o[0]), 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_setclr();
        t_tick();
        t_wave();
        t_inv();
        t_far_duty();
        t_oe_off();
        t_abrupt();
        t_graceful();
        t_cnt_write();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule